// File: doc/BRIEF.md
# Channel-Partitioned Audio Playback FIFO

This block is the sample buffer between a bus-side register interface and the serial formatter of an audio output port. Software writes sample words to a data register. The block keeps the low 24 bits of each word and presents them, oldest first, on a pop/valid drain port that the formatter empties.

The word storage is shared among the active channels. A mono stream can therefore queue many frames, and an eight-channel time-division stream queues far fewer. The fill level is reported in whole frames. Write-while-full and pop-while-empty events leave sticky flags. A level-sensitive request line tells software when the buffer has drained to half its frame capacity.

The format register selects the serial mode, and that mode sets the channel count. A new channel count takes effect only when the FIFO is cleared, so that a partially stored frame can never be read back under a different channel count. The register map is word-indexed through a 2-bit address:

| Address | Register |
|---|---|
| 0 | Format |
| 1 | Control |
| 2 | Status |
| 3 | Sample data (write only) |

Top module: `audio_out_fifo`

## Requirements
- R1: After reset, status reads 0, format reads 0, control reads 0, `dout_valid` is 0 and `irq` is 0; the active channel count is 1.
- R2: A write to the data register (address 3) stores bits 23:0 of the word and drops bits 31:24. Stored words appear on `dout` in write order, and each accepted `pop` advances to the next word.
- R3: The capacity in frames is 256 for 1 channel, 128 for 2, 64 for 3 or 4, and 32 for 5 to 8 channels. These are the values for the default 256-word storage; in general the capacity is the storage divided by 1, 2, 4 or 8. Exactly capacity × channels words are accepted, and `dout_valid` drops after exactly that many pops.
- R4: Status bits 16:8 hold the fill level in frames. A frame is counted when its last word is written and leaves the count when its last word is popped.
- R5: A data write while the FIFO is full is discarded and sets status bit 4. The bit stays set until a clear.
- R6: A pop while `dout_valid` is 0 sets status bit 0. The bit stays set until a clear, and the storage is unchanged.
- R7: Writing control (address 1) with bit 0 set empties the storage, zeroes the fill count and clears both status flags at that clock edge. Control bit 0 then reads 1 for one cycle and 0 afterwards.
- R8: Control bit 20 enables the request. `irq` is high exactly while bit 20 is set and the fill level in frames is at most half the frame capacity.
- R9: Format (address 0) bits 6:4 hold the mode: 0 mono, 1 delayed mono, 2 PCM, 3 I2S, 4 TDM, 5 delayed TDM. Codes 6 and 7 are reserved and give 1 channel. In modes 4 and 5, bits 2:0 give the channel count minus one. Modes 0 and 1 imply 1 channel and modes 2 and 3 imply 2 channels. Format reads back bits 6:4 and 2:0, and every other bit reads 0.
- R10: A format write does not change the active channel count. The count of the current format is adopted only at a clear (R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 format, 1 control, 2 status, 3 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| pop | input | 1 | Drain side takes the word on `dout` |
| dout | output | 24 | Oldest stored sample word |
| dout_valid | output | 1 | At least one word is stored |
| irq | output | 1 | Half-empty request (level) |

## Verification
The bench builds the block with 32 words of storage instead of 256. This gives frame capacities of 32, 16, 8 and 4, so every channel count from 1 to 8 can be filled to the brim and drained completely in a short run.

At that size the bench walks all eight mode codes and all eight TDM channel counts. For each configuration it checks the fill level and request after every single write and pop, the overrun at the full boundary and the underrun at the empty one. It also checks the deferred channel-count change between configurations.

// File: rtl/afifo_pkg.sv
// Package for the audio playback FIFO.
// Holds the register indices, the bit positions the block decodes, the mode
// encoding, and the helpers that turn a format setting into a channel count
// and a capacity shift. Assumes at most 8 channels.
package afifo_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] IDX_FMT  = 2'd0;
    localparam logic [ADDR_W-1:0] IDX_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] IDX_STAT = 2'd2;
    localparam logic [ADDR_W-1:0] IDX_DATA = 2'd3;

    localparam int CTRL_CLR_POS  = 0;
    localparam int CTRL_HALF_POS = 20;
    localparam int STAT_UND_POS  = 0;
    localparam int STAT_OVR_POS  = 4;
    localparam int STAT_LVL_LSB  = 8;
    localparam int STAT_LVL_W    = 9;
    localparam int FMT_MODE_LSB  = 4;
    localparam int CH_W          = 4;

    typedef enum logic [2:0] {
        MODE_MONO     = 3'd0,
        MODE_MONO_DLY = 3'd1,
        MODE_PCM      = 3'd2,
        MODE_I2S      = 3'd3,
        MODE_TDM      = 3'd4,
        MODE_TDM_DLY  = 3'd5,
        MODE_RSV6     = 3'd6,
        MODE_RSV7     = 3'd7
    } fmt_mode_e;

    // Channel count implied by a mode and its TDM channel field.
    function automatic logic [CH_W-1:0] chans_of(fmt_mode_e m, logic [2:0] tch);
        logic [CH_W-1:0] c;
        case (m)
            MODE_PCM, MODE_I2S:     c = 4'd2;
            MODE_TDM, MODE_TDM_DLY: c = {1'b0, tch} + 4'd1;
            default:                c = 4'd1;
        endcase
        return c;
    endfunction

    // Right shift of the word storage that yields the frame capacity.
    function automatic logic [1:0] cap_shift(logic [CH_W-1:0] ch);
        logic [1:0] s;
        if (ch <= 4'd1)      s = 2'd0;
        else if (ch == 4'd2) s = 2'd1;
        else if (ch <= 4'd4) s = 2'd2;
        else                 s = 2'd3;
        return s;
    endfunction

endpackage

// File: rtl/afifo_regs.sv
// Register block for the audio playback FIFO.
// Holds the format register and the control register, and decodes writes
// into a clear pulse and data pushes. The active channel count and the
// capacities derived from it are latched only when a clear is written, so
// stored frames never change shape. Assumes DEPTH_WORDS is a multiple of 8.
module afifo_regs
    import afifo_pkg::*;
#(
    parameter int DEPTH_WORDS = 256,
    parameter int DATA_W      = 24,
    localparam int CNT_W      = $clog2(DEPTH_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output fmt_mode_e         mode_q,
    output logic [2:0]        tch_q,
    output logic              half_en_q,
    output logic              clr_q,
    output logic              clear_now,
    output logic              data_wr,
    output logic [DATA_W-1:0] data_word,
    output logic [CH_W-1:0]   act_ch,
    output logic [CNT_W-1:0]  cap_frames,
    output logic [CNT_W-1:0]  cap_words
);

    logic            unused_hi;
    logic [CH_W-1:0] nxt_ch;
    logic [1:0]      nxt_sh;
    int unsigned     nxt_frames;
    int unsigned     nxt_words;

    assign unused_hi = ^reg_wdata[31:DATA_W];

    // Decode the write strobes for the clear command and the data port.
    always_comb begin
        clear_now = reg_wr && (reg_addr == IDX_CTRL) && reg_wdata[CTRL_CLR_POS];
        data_wr   = reg_wr && (reg_addr == IDX_DATA);
        data_word = reg_wdata[DATA_W-1:0];
    end

    // Work out the channel count and capacities the current format would give.
    always_comb begin
        nxt_ch     = chans_of(mode_q, tch_q);
        nxt_sh     = cap_shift(nxt_ch);
        nxt_frames = DEPTH_WORDS >> nxt_sh;
        nxt_words  = nxt_frames * nxt_ch;
    end

    // Format register: mode field and TDM channel field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_MONO;
            tch_q  <= 3'd0;
        end else if (reg_wr && reg_addr == IDX_FMT) begin
            mode_q <= fmt_mode_e'(reg_wdata[FMT_MODE_LSB +: 3]);
            tch_q  <= reg_wdata[2:0];
        end
    end

    // Control register: threshold enable and the self-clearing clear bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_en_q <= 1'b0;
            clr_q     <= 1'b0;
        end else if (reg_wr && reg_addr == IDX_CTRL) begin
            half_en_q <= reg_wdata[CTRL_HALF_POS];
            clr_q     <= reg_wdata[CTRL_CLR_POS];
        end else begin
            clr_q     <= 1'b0;
        end
    end

    // Adopt the channel layout of the current format at a clear only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_ch     <= 4'd1;
            cap_frames <= CNT_W'(DEPTH_WORDS);
            cap_words  <= CNT_W'(DEPTH_WORDS);
        end else if (clear_now) begin
            act_ch     <= nxt_ch;
            cap_frames <= CNT_W'(nxt_frames);
            cap_words  <= CNT_W'(nxt_words);
        end
    end

    // R7
    clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q && !clear_now |=> !clr_q);

    // R10
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_now |=> $stable(act_ch));

endmodule

// File: rtl/afifo_store.sv
// Word storage for the audio playback FIFO.
// A circular buffer whose pointers wrap at the active word capacity, which
// can be less than the physical depth (3, 5, 6 or 7 channels). Assumes the
// caller only pushes when not full and only pops when not empty.
module afifo_store #(
    parameter int DEPTH_WORDS = 256,
    parameter int DATA_W      = 24,
    localparam int PTR_W      = $clog2(DEPTH_WORDS),
    localparam int CNT_W      = $clog2(DEPTH_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cap_words,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH_WORDS];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  last_idx;

    assign last_idx = PTR_W'(cap_words - CNT_W'(1));
    assign rdata    = mem[rd_ptr];

    // Write the pushed word into the array.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Advance the write pointer, wrapping at the active capacity.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
        end else if (push) begin
            wr_ptr <= (wr_ptr == last_idx) ? '0 : wr_ptr + PTR_W'(1);
        end
    end

    // Advance the read pointer, wrapping at the active capacity.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_ptr <= '0;
        end else if (pop) begin
            rd_ptr <= (rd_ptr == last_idx) ? '0 : rd_ptr + PTR_W'(1);
        end
    end

endmodule

// File: rtl/afifo_track.sv
// Level tracking for the audio playback FIFO.
// Counts stored words, and counts whole frames through write-side and
// read-side position counters, so no divider is needed. Also gates pushes
// and pops, keeps the sticky overrun and underrun flags, and drives the
// half-empty request. A clear in the same cycle wins over any access.
module afifo_track
    import afifo_pkg::*;
#(
    parameter int DEPTH_WORDS = 256,
    localparam int CNT_W      = $clog2(DEPTH_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             half_en,
    input  logic [CH_W-1:0]  act_ch,
    input  logic [CNT_W-1:0] cap_frames,
    input  logic [CNT_W-1:0] cap_words,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             not_empty,
    output logic [CNT_W-1:0] frames,
    output logic             ovr_q,
    output logic             und_q,
    output logic             irq
);

    logic [CNT_W-1:0] words;
    logic [2:0]       wsub;
    logic [2:0]       rsub;
    logic [2:0]       last_sub;
    logic             full;
    logic             frame_in;
    logic             frame_out;

    // Decide which accesses are taken this cycle.
    always_comb begin
        last_sub  = 3'(act_ch - 4'd1);
        full      = (words == cap_words);
        not_empty = (words != '0);
        push_ok   = push_req && !full && !clear;
        pop_ok    = pop_req && not_empty && !clear;
        frame_in  = push_ok && (wsub == last_sub);
        frame_out = pop_ok && (rsub == last_sub);
        irq       = half_en && (frames <= (cap_frames >> 1));
    end

    // Word count: up on a push, down on a pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            words <= '0;
        end else if (push_ok && !pop_ok) begin
            words <= words + CNT_W'(1);
        end else if (pop_ok && !push_ok) begin
            words <= words - CNT_W'(1);
        end
    end

    // Position of the next written and next popped word within its frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wsub <= '0;
            rsub <= '0;
        end else begin
            if (push_ok) wsub <= (wsub == last_sub) ? '0 : wsub + 3'd1;
            if (pop_ok)  rsub <= (rsub == last_sub) ? '0 : rsub + 3'd1;
        end
    end

    // Frame count: completed frames written, less frames fully drained.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            frames <= '0;
        end else if (frame_in && !frame_out) begin
            frames <= frames + CNT_W'(1);
        end else if (frame_out && !frame_in) begin
            frames <= frames - CNT_W'(1);
        end
    end

    // Sticky error flags, removed only by a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ovr_q <= 1'b0;
            und_q <= 1'b0;
        end else begin
            if (push_req && full)      ovr_q <= 1'b1;
            if (pop_req && !not_empty) und_q <= 1'b1;
        end
    end

    // R3
    word_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        words <= cap_words);

    // R4
    frame_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frames <= cap_frames);

    // R5
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q && !clear |=> ovr_q);

    // R6
    und_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        und_q && !clear |=> und_q);

    // R7
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (words == '0) && (frames == '0) && !ovr_q && !und_q);

endmodule

// File: rtl/audio_out_fifo.sv
// Top of the channel-partitioned audio playback FIFO.
// Joins the register block, the word storage and the level tracker, and
// builds the combinational register read data. Assumes a single register
// port: reads have no side effects and the data register is write-only.
module audio_out_fifo
    import afifo_pkg::*;
#(
    parameter int DEPTH_WORDS = 256,
    parameter int DATA_W      = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              irq
);

    localparam int CNT_W = $clog2(DEPTH_WORDS + 1);

    fmt_mode_e         mode_q;
    logic [2:0]        tch_q;
    logic              half_en_q;
    logic              clr_q;
    logic              clear_now;
    logic              data_wr;
    logic [DATA_W-1:0] data_word;
    logic [CH_W-1:0]   act_ch;
    logic [CNT_W-1:0]  cap_frames;
    logic [CNT_W-1:0]  cap_words;
    logic              push_ok;
    logic              pop_ok;
    logic [CNT_W-1:0]  frames;
    logic              ovr_q;
    logic              und_q;

    afifo_regs #(.DEPTH_WORDS(DEPTH_WORDS), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .mode_q     (mode_q),
        .tch_q      (tch_q),
        .half_en_q  (half_en_q),
        .clr_q      (clr_q),
        .clear_now  (clear_now),
        .data_wr    (data_wr),
        .data_word  (data_word),
        .act_ch     (act_ch),
        .cap_frames (cap_frames),
        .cap_words  (cap_words)
    );

    afifo_store #(.DEPTH_WORDS(DEPTH_WORDS), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_now),
        .push      (push_ok),
        .pop       (pop_ok),
        .wdata     (data_word),
        .cap_words (cap_words),
        .rdata     (dout)
    );

    afifo_track #(.DEPTH_WORDS(DEPTH_WORDS)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_now),
        .push_req   (data_wr),
        .pop_req    (pop),
        .half_en    (half_en_q),
        .act_ch     (act_ch),
        .cap_frames (cap_frames),
        .cap_words  (cap_words),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok),
        .not_empty  (dout_valid),
        .frames     (frames),
        .ovr_q      (ovr_q),
        .und_q      (und_q),
        .irq        (irq)
    );

    // Select the register image addressed by reg_addr.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IDX_FMT: begin
                reg_rdata[FMT_MODE_LSB +: 3] = mode_q;
                reg_rdata[2:0]               = tch_q;
            end
            IDX_CTRL: begin
                reg_rdata[CTRL_HALF_POS] = half_en_q;
                reg_rdata[CTRL_CLR_POS]  = clr_q;
            end
            IDX_STAT: begin
                reg_rdata[STAT_LVL_LSB +: STAT_LVL_W] = STAT_LVL_W'(frames);
                reg_rdata[STAT_OVR_POS]               = ovr_q;
                reg_rdata[STAT_UND_POS]               = und_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !half_en_q |-> !irq);

    // R2
    pop_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !dout_valid && !clear_now |=> !dout_valid || $past(data_wr));

endmodule

// File: tb/sim_audio_out_fifo.sv
module sim_audio_out_fifo;

    localparam int D = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pop = 1'b0;
    logic [23:0] dout;
    logic        dout_valid;
    logic        irq;

    int vec = 0;
    int bad = 0;

    always #4 clk = ~clk;

    audio_out_fifo #(.DEPTH_WORDS(D), .DATA_W(24)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pop(pop),
        .dout(dout), .dout_valid(dout_valid), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic do_pop();
        @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    function automatic int exp_ch(int m, int t);
        if (m == 2 || m == 3) return 2;
        if (m == 4 || m == 5) return t + 1;
        return 1;
    endfunction

    function automatic int exp_cap(int ch);
        if (ch <= 1) return D;
        if (ch == 2) return D / 2;
        if (ch <= 4) return D / 4;
        return D / 8;
    endfunction

    function automatic logic [31:0] pat(int k, int m, int t);
        return 32'h5A00_0000 | (32'(k * 66051 + m * 977 + t * 131) & 32'h00FF_FFFF);
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        vec++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int prev_ch;
        int ch;
        int cap;
        int cw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rreg(2'd2, v); chk("R1 status", v, 32'h0);
        rreg(2'd0, v); chk("R1 format", v, 32'h0);
        rreg(2'd1, v); chk("R1 control", v, 32'h0);
        chk("R1 dout_valid", 32'(dout_valid), 32'h0);
        chk("R8 irq disabled while empty", 32'(irq), 32'h0);

        prev_ch = 1;
        for (int m = 0; m < 8; m++) begin
            for (int t = 0; t < 8; t++) begin
                if (!(m == 4 || m == 5) && t != 7) continue;
                // R9 format readback, stray bits dropped
                wreg(2'd0, 32'hFFFF_FF88 & ~32'h77 | 32'(m << 4) | 32'(t));
                rreg(2'd0, v); chk("R9 format readback", v, 32'(m << 4) | 32'(t));
                // R10 old channel count still in force before a clear
                wreg(2'd3, 32'h00AB_CDEF);
                rreg(2'd2, v);
                chk("R10 frames before clear", (v >> 8) & 32'h1FF, (prev_ch == 1) ? 32'd1 : 32'd0);
                // R7 clear with threshold enabled
                wreg(2'd1, 32'h0010_0001);
                rreg(2'd1, v); chk("R7 clear bit visible", v, 32'h0010_0001);
                rreg(2'd2, v); chk("R7 status after clear", v, 32'h0);
                chk("R7 dout_valid after clear", 32'(dout_valid), 32'h0);
                @(negedge clk);
                rreg(2'd1, v); chk("R7 clear bit self-clears", v, 32'h0010_0000);
                chk("R8 irq when empty", 32'(irq), 32'h1);

                ch  = exp_ch(m, t);
                cap = exp_cap(ch);
                cw  = cap * ch;
                for (int k = 0; k < cw; k++) begin
                    wreg(2'd3, pat(k, m, t));
                    rreg(2'd2, v);
                    chk("R4 fill frames", (v >> 8) & 32'h1FF, 32'((k + 1) / ch));
                    chk("R8 irq level", 32'(irq), 32'(((k + 1) / ch) <= cap / 2));
                end
                // R3 and R5 full boundary
                wreg(2'd3, 32'h0077_7777);
                rreg(2'd2, v);
                chk("R3 R5 full and overrun", v, 32'(cap << 8) | 32'h10);
                for (int k = 0; k < cw; k++) begin
                    chk("R3 valid while stored", 32'(dout_valid), 32'h1);
                    chk("R2 drain order and mask", 32'(dout), pat(k, m, t) & 32'h00FF_FFFF);
                    do_pop();
                    rreg(2'd2, v);
                    chk("R4 drain frames", (v >> 8) & 32'h1FF, 32'(cap - (k + 1) / ch));
                end
                chk("R3 empty after capacity", 32'(dout_valid), 32'h0);
                do_pop();
                rreg(2'd2, v);
                chk("R6 underrun flag", v, 32'h11);
                chk("R6 still empty", 32'(dout_valid), 32'h0);
                prev_ch = ch;
            end
        end
        finish_run();
    end

endmodule